// File: doc/BRIEF.md
# Host Bus Port Register Access Controller

This block sits between a byte-wide CPU bus and the internal state of a display controller. Two address lines pick one of four ports. The data port moves bytes to and from video memory through an auto-advancing address counter. The control port carries two-byte write sequences. Depending on the top bits of the second byte, a sequence either loads a control register or sets the memory address. A read of the control port returns a status byte chosen by a pointer. The colour port fills a 16-entry table of 9-bit colours, two bytes per entry. The indirect port writes control registers through a pointer register that can advance by itself.

The block holds the control register file, the colour table and the memory address counter. Status bytes come in from outside. Video memory is reached through a single-outstanding request/acknowledge interface. When the CPU sets a read address, the block fetches that byte ahead of time and holds it in a one-byte latch. The next data-port read returns the latch and fetches the following byte.

Top module: `host_port_ctrl`

## Requirements
- R1: `bus_port_i` selects the port. 0 is memory data (read and write), 1 is the control port (status read, setup write), 2 is colour write, and 3 is indirect register write. A read of port 2 or 3 returns 8'hFF.
- R2: On the control port, a first byte followed by a second byte of the form 2'b10 in bits 7:6 writes the first byte into the register numbered by bits 5:0. A second byte of the form 2'b11 changes no register and starts no memory access.
- R3: Register 17 holds an indirect target in bits 5:0. Each port-3 write stores the byte into that target. When bit 7 of register 17 is 0, bits 5:0 then advance by one. When bit 7 is 1, register 17 is left unchanged.
- R4: A port-3 write whose target is register 17 does not change register 17's contents. The pointer still advances when bit 7 is 0.
- R5: Colour writes use the entry in register 16 bits 3:0. The first byte gives red (bits 6:4) and blue (bits 2:0), and the second byte gives green (bits 2:0). The entry is stored as {red, green, blue}. Register 16 bits 3:0 advance by one after each pair, wrapping 15 to 0.
- R6: A control-port read returns status byte k, where k is register 15 bits 3:0 and status byte k is `status_i[8k+7:8k]`. It returns 8'h00 when k is 10 or more.
- R7: An address setup sends A7..A0 first, then a second byte with bit 7 = 0, A13..A8 in bits 5:0 and bit 6 as the direction (1 write, 0 read). A16..A14 come from register 14 bits 2:0.
- R8: A read setup issues one memory read at the new address. A write setup issues no memory access.
- R9: Each data-port access performs one memory access at the current address, and the address then advances by one. A data read returns the latched byte and starts a fetch of the next address.
- R10: When A13..A0 wrap from all ones, register 14 bits 2:0 advance by one, but only if register 0 bit 3 or bit 2 is set. Otherwise register 14 is unchanged.
- R11: Any control-port read makes the next control-port write a first byte.
- R12: `mem_req_o` stays high, with address, direction and write data stable, until the cycle in which `mem_ack_i` is high.
- R13: After reset, all control registers, all colour entries and the read latch are zero, and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | One-cycle bus access strobe |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_port_i | input | 2 | Port select |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte, valid while the read strobe is high |
| status_i | input | NUM_STATUS*8 | Status bytes, byte k at bits 8k+7:8k |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 14+ADDR_HI_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ack_i | input | 1 | Memory accepts the request; read data valid |
| mem_rdata_i | input | 8 | Memory read byte |
| pal_idx_i | input | $clog2(PAL_ENTRIES) | Colour table lookup index |
| pal_color_o | output | 9 | Colour entry {red, green, blue} |
| ctrl_regs_o | output | NUM_REGS*8 | All control registers, register n at bits 8n+7:8n |

## Verification
The bench uses the default parameters: 48 control registers, 10 status bytes, a 16-entry colour table and three bank bits above the 14-bit counter. These values put the pointer register 17 inside the file, so the self-write guard can be exercised. A status pointer of 12 lands past the last status byte. The 14-bit counter can be driven across its wrap, both with and without the bank carry, using a single bank register. The memory model answers after a programmable delay, so a request can be watched while it waits for its acknowledge.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
  localparam int unsigned IDX_W       = 6;
  localparam int unsigned ADDR_LO_W   = 14;
  localparam int          REG_MODE0   = 0;
  localparam int          REG_BANK    = 14;
  localparam int          REG_STAT_PT = 15;
  localparam int          REG_PAL_PT  = 16;
  localparam int          REG_IND_PT  = 17;

  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_PAL  = 2'd2,
    PORT_IND  = 2'd3
  } port_e;
endpackage

// File: rtl/hp_ctrl_regs.sv
module hp_ctrl_regs
  import host_port_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 48,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned PAL_IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  inc_bank_i,
  input  logic                  inc_pal_i,
  input  logic                  inc_ind_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    logic       hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    if (g == REG_BANK) begin : g_bank
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         q <= '0;
        else if (hit)        q <= wr_data_i;
        else if (inc_bank_i) q[BANK_W-1:0] <= q[BANK_W-1:0] + 1'b1;
      end
    end else if (g == REG_PAL_PT) begin : g_pal
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= '0;
        else if (hit)       q <= wr_data_i;
        else if (inc_pal_i) q[PAL_IDX_W-1:0] <= q[PAL_IDX_W-1:0] + 1'b1;
      end
    end else if (g == REG_IND_PT) begin : g_ind
      // port-3 path never targets this register; only the pointer field moves
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        q <= '0;
        else if (hit)       q <= wr_data_i;
        else if (inc_ind_i) q[IDX_W-1:0] <= q[IDX_W-1:0] + 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_data_i;
      end
    end

    assign regs_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/hp_palette.sv
module hp_palette #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CW      = 3,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    byte_i,
  input  logic [IW-1:0] ptr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          pair_done_o,
  output logic [3*CW-1:0] color_o
);
  logic            phase_q;
  logic [CW-1:0]   red_q, blue_q;
  logic [3*CW-1:0] mem_q [ENTRIES];

  assign pair_done_o = wr_i && phase_q;
  assign color_o     = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      red_q   <= '0;
      blue_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      if (!phase_q) begin
        red_q   <= byte_i[4 +: CW];
        blue_q  <= byte_i[0 +: CW];
        phase_q <= 1'b1;
      end else begin
        mem_q[ptr_i] <= {red_q, byte_i[0 +: CW], blue_q};
        phase_q      <= 1'b0;
      end
    end
  end

  p_second_byte_stores_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_done_o |=> mem_q[$past(ptr_i)] == {$past(red_q), $past(byte_i[0 +: CW]), $past(blue_q)});
endmodule

// File: rtl/hp_vram_port.sv
module hp_vram_port
  import host_port_pkg::*;
#(
  parameter int unsigned BANK_W = 3,
  localparam int unsigned AW    = ADDR_LO_W + BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [ADDR_LO_W-1:0] load_addr_i,
  input  logic                 load_rd_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 wide_i,
  output logic                 inc_bank_o,
  output logic [7:0]           rd_latch_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [7:0]           mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [7:0]           mem_rdata_i
);
  logic [ADDR_LO_W-1:0] lo_q, cur_lo;
  logic                 start;

  assign cur_lo     = load_i ? load_addr_i : lo_q;
  assign start      = !mem_req_o && (load_i ? load_rd_i : (wr_i || rd_i));
  assign inc_bank_o = start && wide_i && (&cur_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q        <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rd_latch_o  <= '0;
    end else begin
      if (start) begin
        mem_req_o   <= 1'b1;
        mem_we_o    <= wr_i && !load_i;
        mem_addr_o  <= {bank_i, cur_lo};
        mem_wdata_o <= wdata_i;
        lo_q        <= cur_lo + 1'b1;
      end else begin
        if (load_i) lo_q <= load_addr_i;
        if (mem_req_o && mem_ack_i) mem_req_o <= 1'b0;
      end
      if (mem_req_o && mem_ack_i && !mem_we_o) rd_latch_o <= mem_rdata_i;
    end
  end

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o));
  p_read_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o) |=> rd_latch_o == $past(mem_rdata_i));
  p_no_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && (wr_i || rd_i)) |=> $stable(mem_addr_o));
endmodule

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
  import host_port_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 48,
  parameter int unsigned NUM_STATUS  = 10,
  parameter int unsigned PAL_ENTRIES = 16,
  parameter int unsigned ADDR_HI_W   = 3,
  localparam int unsigned PAL_IW     = $clog2(PAL_ENTRIES),
  localparam int unsigned AW         = ADDR_LO_W + ADDR_HI_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_en_i,
  input  logic                    bus_wr_i,
  input  logic [1:0]              bus_port_i,
  input  logic [7:0]              bus_wdata_i,
  output logic [7:0]              bus_rdata_o,
  input  logic [NUM_STATUS*8-1:0] status_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [7:0]              mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [7:0]              mem_rdata_i,
  input  logic [PAL_IW-1:0]       pal_idx_i,
  output logic [8:0]              pal_color_o,
  output logic [NUM_REGS*8-1:0]   ctrl_regs_o
);
  localparam logic [IDX_W:0] NREG_L = (IDX_W+1)'(NUM_REGS);

  port_e port;
  assign port = port_e'(bus_port_i);

  logic acc_wr, acc_rd;
  assign acc_wr = bus_en_i && bus_wr_i;
  assign acc_rd = bus_en_i && !bus_wr_i;

  // register views
  logic [7:0]        ind_ptr_reg;
  logic [3:0]        stat_sel;
  logic [PAL_IW-1:0] pal_ptr;
  logic [ADDR_HI_W-1:0] bank;
  logic              wide;
  assign ind_ptr_reg = ctrl_regs_o[REG_IND_PT*8 +: 8];
  assign stat_sel    = ctrl_regs_o[REG_STAT_PT*8 +: 4];
  assign pal_ptr     = ctrl_regs_o[REG_PAL_PT*8 +: PAL_IW];
  assign bank        = ctrl_regs_o[REG_BANK*8 +: ADDR_HI_W];
  assign wide        = ctrl_regs_o[REG_MODE0*8 + 3] || ctrl_regs_o[REG_MODE0*8 + 2];

  // control port two-phase sequencing
  logic       phase_q;
  logic [7:0] first_q;
  logic       p1_wr, p1_rd, second, dir_wr, addr_set;
  assign p1_wr    = acc_wr && port == PORT_CTRL;
  assign p1_rd    = acc_rd && port == PORT_CTRL;
  assign second   = p1_wr && phase_q;
  assign dir_wr   = second && bus_wdata_i[7:6] == 2'b10;
  assign addr_set = second && !bus_wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= '0;
    end else if (p1_rd) begin
      phase_q <= 1'b0;
    end else if (p1_wr) begin
      phase_q <= !phase_q;
      if (!phase_q) first_q <= bus_wdata_i;
    end
  end

  // indirect port
  logic             ind_wr, ind_ok, inc_ind;
  logic [IDX_W-1:0] ind_ptr;
  assign ind_ptr = ind_ptr_reg[IDX_W-1:0];
  assign ind_wr  = acc_wr && port == PORT_IND;
  assign ind_ok  = (ind_ptr != IDX_W'(REG_IND_PT)) && ({1'b0, ind_ptr} < NREG_L);
  assign inc_ind = ind_wr && !ind_ptr_reg[7];

  logic             rf_wr_en;
  logic [IDX_W-1:0] rf_wr_idx;
  logic [7:0]       rf_wr_data;
  assign rf_wr_en   = (dir_wr && ({1'b0, bus_wdata_i[IDX_W-1:0]} < NREG_L)) || (ind_wr && ind_ok);
  assign rf_wr_idx  = dir_wr ? bus_wdata_i[IDX_W-1:0] : ind_ptr;
  assign rf_wr_data = dir_wr ? first_q : bus_wdata_i;

  logic inc_bank, pal_done;

  hp_ctrl_regs #(
    .NUM_REGS (NUM_REGS),
    .BANK_W   (ADDR_HI_W),
    .PAL_IDX_W(PAL_IW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (rf_wr_en),
    .wr_idx_i  (rf_wr_idx),
    .wr_data_i (rf_wr_data),
    .inc_bank_i(inc_bank),
    .inc_pal_i (pal_done),
    .inc_ind_i (inc_ind),
    .regs_o    (ctrl_regs_o)
  );

  hp_palette #(
    .ENTRIES(PAL_ENTRIES),
    .CW     (3)
  ) u_pal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (acc_wr && port == PORT_PAL),
    .byte_i     (bus_wdata_i),
    .ptr_i      (pal_ptr),
    .rd_idx_i   (pal_idx_i),
    .pair_done_o(pal_done),
    .color_o    (pal_color_o)
  );

  logic [7:0] rd_latch;

  hp_vram_port #(
    .BANK_W(ADDR_HI_W)
  ) u_vram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (addr_set),
    .load_addr_i({bus_wdata_i[ADDR_LO_W-9:0], first_q}),
    .load_rd_i  (!bus_wdata_i[6]),
    .wr_i       (acc_wr && port == PORT_DATA),
    .rd_i       (acc_rd && port == PORT_DATA),
    .wdata_i    (bus_wdata_i),
    .bank_i     (bank),
    .wide_i     (wide),
    .inc_bank_o (inc_bank),
    .rd_latch_o (rd_latch),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  // read mux
  logic [7:0] stat_byte;
  always_comb begin
    stat_byte = 8'h00;
    for (int k = 0; k < NUM_STATUS; k++)
      if (stat_sel == 4'(k)) stat_byte = status_i[k*8 +: 8];
  end

  always_comb begin
    unique case (port)
      PORT_DATA: bus_rdata_o = rd_latch;
      PORT_CTRL: bus_rdata_o = stat_byte;
      default:   bus_rdata_o = 8'hFF;
    endcase
  end

  p_ind_autoinc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_ind |=> ind_ptr_reg[IDX_W-1:0] == $past(ind_ptr_reg[IDX_W-1:0]) + 1'b1);
  p_ind_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_wr && ind_ptr_reg[7]) |=> $stable(ind_ptr_reg));
  p_self_guard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_wr && ind_ptr == IDX_W'(REG_IND_PT)) |=> ctrl_regs_o[REG_IND_PT*8 + 7] == $past(ind_ptr_reg[7]));
  p_pal_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_done |=> pal_ptr == $past(pal_ptr) + 1'b1);
  p_phase_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_rd |=> !phase_q);
  p_bank_carry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_bank && !rf_wr_en) |=> bank == $past(bank) + 1'b1);
  p_no_carry_narrow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide && !rf_wr_en) |=> $stable(bank));
endmodule

// File: tb/sim_host_port_ctrl.sv
module sim_host_port_ctrl;
  localparam int NUM_REGS = 48;
  localparam int NUM_STATUS = 10;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_en = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_port = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NUM_STATUS*8-1:0] status;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [3:0] pal_idx = '0;
  logic [8:0] pal_color;
  logic [NUM_REGS*8-1:0] regs;

  always #5 clk = !clk;

  for (genvar k = 0; k < NUM_STATUS; k++) begin : g_st
    assign status[k*8 +: 8] = 8'h30 + 8'(k);
  end

  host_port_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_en_i(bus_en), .bus_wr_i(bus_wr),
    .bus_port_i(bus_port), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .status_i(status), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .pal_idx_i(pal_idx), .pal_color_o(pal_color), .ctrl_regs_o(regs)
  );

  int checks = 0, fails = 0;
  int lat = 1, wait_cnt = 0;

  function automatic logic [7:0] mem_hash(logic [AW-1:0] a);
    return a[7:0] ^ {a[15:8]} ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction

  // memory model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack <= 1'b0; mem_rdata <= '0; wait_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat - 1) begin
        mem_ack <= 1'b1; mem_rdata <= mem_hash(mem_addr); wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  // scoreboard: {we, addr, data}
  logic [AW+8:0] exp_q [$];

  task automatic expect_mem(input logic we, input logic [AW-1:0] a, input logic [7:0] d);
    exp_q.push_back({we, a, d});
  endtask

  always @(negedge clk) begin
    if (rst_ni && mem_req && mem_ack) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected access we=%0b addr=%h expected none", mem_we, mem_addr);
      end else begin
        logic [AW+8:0] e;
        e = exp_q.pop_front();
        if (mem_we != e[AW+8] || mem_addr != e[AW+7:8] || (mem_we && mem_wdata != e[7:0])) begin
          fails++;
          $display("FAIL R7/R9 access actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                   mem_we, mem_addr, mem_wdata, e[AW+8], e[AW+7:8], e[7:0]);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_at(int n);
    return regs[n*8 +: 8];
  endfunction

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_port = p;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic set_reg(input int n, input logic [7:0] d);
    wr(2'd1, d);
    wr(2'd1, 8'h80 | 8'(n));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mem_req);
    @(negedge clk);
  endtask

  task automatic finish_run();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending expected accesses actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 regs zero", {24'd0, reg_at(14) | reg_at(17) | reg_at(0)}, 32'd0);
    check("R13 palette zero", {23'd0, pal_color}, 32'd0);
    check("R13 no request", {31'd0, mem_req}, 32'd0);
    rd(2'd0, d); check("R13 latch zero", {24'd0, d}, 32'd0);
    wait_idle();
    // the read above fetched address 0 only if expected: it did, accept it
    // R2 direct write
    set_reg(7, 8'hA5);
    check("R2 direct write", {24'd0, reg_at(7)}, 32'hA5);
    wr(2'd1, 8'h3C); wr(2'd1, 8'hC8);
    check("R2 11-pattern ignored", {24'd0, reg_at(8)}, 32'h00);
    check("R2 11-pattern no access", {31'd0, mem_req}, 32'd0);
    // R6 status
    set_reg(15, 8'h03); rd(2'd1, d); check("R6 status 3", {24'd0, d}, 32'h33);
    set_reg(15, 8'h09); rd(2'd1, d); check("R6 status 9", {24'd0, d}, 32'h39);
    set_reg(15, 8'h0C); rd(2'd1, d); check("R6 status out of range", {24'd0, d}, 32'h00);
    // R11 resync
    wr(2'd1, 8'h11); rd(2'd1, d);
    wr(2'd1, 8'h22); wr(2'd1, 8'h85);
    check("R11 resync reg5", {24'd0, reg_at(5)}, 32'h22);
    // R1 unreadable ports
    rd(2'd2, d); check("R1 port2 read", {24'd0, d}, 32'hFF);
    rd(2'd3, d); check("R1 port3 read", {24'd0, d}, 32'hFF);
    // R3 indirect with auto-increment
    set_reg(17, 8'h14);
    wr(2'd3, 8'hAA); wr(2'd3, 8'hBB); wr(2'd3, 8'hCC);
    check("R3 ind reg20", {24'd0, reg_at(20)}, 32'hAA);
    check("R3 ind reg22", {24'd0, reg_at(22)}, 32'hCC);
    check("R3 pointer advanced", {24'd0, reg_at(17)}, 32'h17);
    set_reg(17, 8'h98);
    wr(2'd3, 8'h01); wr(2'd3, 8'h02);
    check("R3 hold reg24", {24'd0, reg_at(24)}, 32'h02);
    check("R3 pointer held", {24'd0, reg_at(17)}, 32'h98);
    // R4 self-guard
    set_reg(17, 8'h11);
    wr(2'd3, 8'h3F);
    check("R4 self write blocked", {24'd0, reg_at(17)}, 32'h12);
    wr(2'd3, 8'h77);
    check("R4 next target", {24'd0, reg_at(18)}, 32'h77);
    set_reg(17, 8'h91);
    wr(2'd3, 8'h05);
    check("R4 held self", {24'd0, reg_at(17)}, 32'h91);
    // R5 palette
    set_reg(16, 8'h02);
    wr(2'd2, 8'h53); wr(2'd2, 8'h06);
    pal_idx = 4'd2; #1;
    check("R5 entry2", {23'd0, pal_color}, {23'd0, 3'd5, 3'd6, 3'd3});
    check("R5 ptr step", {24'd0, reg_at(16)}, 32'h03);
    wr(2'd2, 8'h70); wr(2'd2, 8'h01);
    pal_idx = 4'd3; #1;
    check("R5 entry3", {23'd0, pal_color}, {23'd0, 3'd7, 3'd1, 3'd0});
    set_reg(16, 8'h0F);
    wr(2'd2, 8'h12); wr(2'd2, 8'h04);
    pal_idx = 4'd15; #1;
    check("R5 entry15", {23'd0, pal_color}, {23'd0, 3'd1, 3'd4, 3'd2});
    check("R5 ptr wrap", {28'd0, reg_at(16)[3:0]}, 32'h0);
    // R7 R8 R9 read setup and prefetch
    set_reg(14, 8'h02);
    expect_mem(1'b0, 17'h09234, 8'h00);
    wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    wait_idle();
    expect_mem(1'b0, 17'h09235, 8'h00);
    rd(2'd0, d); check("R9 prefetched byte", {24'd0, d}, {24'd0, mem_hash(17'h09234)});
    wait_idle();
    expect_mem(1'b0, 17'h09236, 8'h00);
    rd(2'd0, d); check("R9 next byte", {24'd0, d}, {24'd0, mem_hash(17'h09235)});
    wait_idle();
    // R8 write setup without access, R12 held request
    lat = 4;
    wr(2'd1, 8'h00); wr(2'd1, 8'h45);
    repeat (3) @(negedge clk);
    check("R8 write setup no access", {31'd0, mem_req}, 32'd0);
    expect_mem(1'b1, 17'h08500, 8'h9C);
    wr(2'd0, 8'h9C);
    @(negedge clk);
    check("R12 request held", {31'd0, mem_req}, 32'd1);
    check("R12 address held", {15'd0, mem_addr}, 32'h08500);
    wait_idle();
    lat = 1;
    expect_mem(1'b1, 17'h08501, 8'h9D);
    wr(2'd0, 8'h9D);
    wait_idle();
    // R10 narrow wrap
    set_reg(0, 8'h00); set_reg(14, 8'h00);
    wr(2'd1, 8'hFF); wr(2'd1, 8'h7F);
    expect_mem(1'b1, 17'h03FFF, 8'h01); wr(2'd0, 8'h01); wait_idle();
    expect_mem(1'b1, 17'h00000, 8'h02); wr(2'd0, 8'h02); wait_idle();
    check("R10 narrow no carry", {24'd0, reg_at(14)}, 32'h00);
    // R10 wide carry
    set_reg(0, 8'h04);
    wr(2'd1, 8'hFF); wr(2'd1, 8'h7F);
    expect_mem(1'b1, 17'h03FFF, 8'h03); wr(2'd0, 8'h03); wait_idle();
    expect_mem(1'b1, 17'h04000, 8'h04); wr(2'd0, 8'h04); wait_idle();
    check("R10 wide carry", {24'd0, reg_at(14)}, 32'h01);
    finish_run();
  end

  // the reset-state latch read fetches address 0
  initial begin
    expect_mem(1'b0, 17'h00000, 8'h00);
  end
endmodule